// File: doc/BRIEF.md
# Swap Log Drain Scheduler

This block lives in the interface of an I/O node that sits on a recirculating write-cache ring. The ring has one channel per node. Every time a node parks a swapped-out page on its own channel, the I/O node receives a notification. The block logs that notification as a record holding the swapping node and the page number, in a per-channel queue. When the attached disk cache reports that it has room, the block picks the channel holding the most records. It then copies records from that channel one per cycle, oldest first, and acknowledges each page to its swapper. Consecutive swap-outs from one node therefore reach the disk cache back to back, so they can be combined into a single disk write.

A node that faults on a page still circulating on the ring sends a cancel naming the channel and the page. The matching record is removed without any disk write, and the original swapper receives its acknowledgement on a separate cancel-acknowledge port. Payload transport and page-table state are handled elsewhere.

The control is a two-state machine. In `ST_IDLE` the SELECT transition fires when `room` is high and any channel holds a record: the fullest channel is latched and the machine moves to `ST_DRAIN`. In `ST_DRAIN` the machine holds on the latched channel, popping one record per cycle in which `room` is high. The EXHAUST transition back to `ST_IDLE` fires in the first cycle that the latched channel is seen empty.

Top module: `swap_log_drain`

## Requirements
- R1: After reset all channel queues are empty, the machine is in `ST_IDLE`, and every output valid, `swap_refused` and `cancel_miss` are low; with no records logged, `room` produces no writes.
- R2: A swap notification to a channel holding fewer than DEPTH (16) records is appended at its tail. One to a channel that holds DEPTH records at that edge is not stored, and `swap_refused` pulses in the following cycle, even if a record leaves that channel in the same cycle.
- R3: In `ST_IDLE` with `room` high, the channel holding the most records is selected; among equal counts, the lowest channel index wins.
- R4: In `ST_DRAIN`, each cycle with `room` high and a non-empty selected channel removes that channel's oldest record. In the next cycle `wr_valid` is high, with `wr_chan` and `wr_page` carrying the channel and the page.
- R5: The machine stays on the selected channel until it is observed empty. This includes records appended to it during the drain. Low `room` pauses the drain without switching channels.
- R6: Every drained record raises `ack_valid` in the same cycle as its write, with `ack_node` and `ack_page` equal to the record's swapper and page.
- R7: A cancel whose page is present in the named channel removes the oldest record with that page number. The remaining records keep their order. The next cycle raises `cack_valid` with that record's node and page, and no write of it ever happens.
- R8: A cancel whose page is absent from the named channel changes no queue and pulses `cancel_miss` in the next cycle.
- R9: A cancel naming the record being drained in the same cycle is absorbed by the drain: exactly one acknowledgement (`ack_valid`) is produced, and neither `cack_valid` nor `cancel_miss` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swap_valid | input | 1 | Swap-out notification present |
| swap_chan | input | 3 | Ring channel the page was parked on |
| swap_node | input | 3 | Node that swapped the page out |
| swap_page | input | 16 | Swapped page number |
| swap_refused | output | 1 | Previous notification hit a full channel |
| room | input | 1 | Disk cache can accept a page this cycle |
| cancel_valid | input | 1 | Re-fetch cancel present |
| cancel_chan | input | 3 | Channel holding the re-fetched page |
| cancel_page | input | 16 | Re-fetched page number |
| cancel_miss | output | 1 | Previous cancel found no matching record |
| wr_valid | output | 1 | Page copy to the disk cache issued |
| wr_chan | output | 3 | Channel the page is copied from |
| wr_page | output | 16 | Page being copied |
| ack_valid | output | 1 | Acknowledge for a drained page |
| ack_node | output | 3 | Swapper receiving the drain acknowledge |
| ack_page | output | 16 | Page being acknowledged |
| cack_valid | output | 1 | Acknowledge for a cancelled page |
| cack_node | output | 3 | Swapper receiving the cancel acknowledge |
| cack_page | output | 16 | Cancelled page |

## Verification
The assertions guard the properties that hold locally every cycle:
- a queue never exceeds its depth, and a push to a full queue never grows it;
- a pop never hits an empty queue, and writes only follow drain cycles;
- the machine never leaves a non-empty selected channel;
- the picked channel's count dominates all others, with ties going low;
- a same-cycle cancel on the drained head yields neither a cancel acknowledge nor a miss.

Only the bench's scenarios can show that pages leave in the order they were swapped. They also show that a mid-queue cancel leaves the survivors in order, that refusals are not stored, and that the sequence of channels visited follows the load ranking. A behavioural queue model compares every output on every clock to establish these.

// File: rtl/swap_drain_pkg.sv
package swap_drain_pkg;

    // Scheduler control states.
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } drain_state_e;

endpackage

// File: rtl/swap_chan_log.sv
// One channel's log of swap-out records, kept as a compacting shift array:
// entry 0 is the oldest; removal from any slot closes the gap in order.
module swap_chan_log #(
    parameter int DEPTH  = 16,
    parameter int NODE_W = 3,
    parameter int PAGE_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_en,
    input  logic [NODE_W+PAGE_W-1:0]      push_rec,
    input  logic                          pop_en,
    input  logic                          cancel_en,
    input  logic [PAGE_W-1:0]             cancel_page,
    output logic [NODE_W+PAGE_W-1:0]      head_rec,
    output logic [$clog2(DEPTH+1)-1:0]    fill,
    output logic                          full,
    output logic                          cancel_hit,
    output logic                          cancel_taken,
    output logic [NODE_W+PAGE_W-1:0]      cancel_rec
);
    localparam int REC_W = NODE_W + PAGE_W;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [REC_W-1:0] mem_q [DEPTH];
    logic [REC_W-1:0] mem_d [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [IDX_W-1:0] match_idx;

    assign full     = (cnt_q == CNT_W'(DEPTH));
    assign fill     = cnt_q;
    assign head_rec = mem_q[0];

    // Oldest live record whose page matches the cancel.
    always_comb begin
        cancel_hit = 1'b0;
        match_idx  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!cancel_hit && (CNT_W'(i) < cnt_q) &&
                (mem_q[i][PAGE_W-1:0] == cancel_page)) begin
                cancel_hit = 1'b1;
                match_idx  = IDX_W'(i);
            end
        end
    end

    // A drain popping the same head absorbs the cancel.
    assign cancel_taken = cancel_en && cancel_hit && !(pop_en && (match_idx == '0));
    assign cancel_rec   = mem_q[match_idx];

    always_comb begin
        mem_d = mem_q;
        cnt_d = cnt_q;
        if (cancel_taken) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= match_idx) mem_d[i] = mem_d[i+1];
            end
            cnt_d = cnt_d - CNT_W'(1);
        end
        if (pop_en) begin
            for (int i = 0; i < DEPTH - 1; i++) mem_d[i] = mem_d[i+1];
            cnt_d = cnt_d - CNT_W'(1);
        end
        if (push_en && !full) begin
            mem_d[cnt_d[IDX_W-1:0]] = push_rec;
            cnt_d = cnt_d + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    // R2: occupancy never exceeds the channel's capacity.
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R2: a notification arriving at a full log never grows it.
    assert_full_refuses_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && full) |=> (cnt_q <= $past(cnt_q)));

    // R4: the drain only pops a log that holds something.
    assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> (cnt_q != '0));

endmodule

// File: rtl/swap_load_picker.sv
// Index of the largest occupancy; strict compare keeps the lowest index on ties.
module swap_load_picker #(
    parameter int NCH   = 8,
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0]         fill [NCH],
    output logic [$clog2(NCH)-1:0]   best,
    output logic                     any_loaded
);
    localparam int CH_W = $clog2(NCH);

    logic [CNT_W-1:0] top_cnt;

    always_comb begin
        best    = '0;
        top_cnt = fill[0];
        for (int i = 1; i < NCH; i++) begin
            if (fill[i] > top_cnt) begin
                top_cnt = fill[i];
                best    = CH_W'(i);
            end
        end
        any_loaded = (top_cnt != '0);
    end

endmodule

// File: rtl/swap_log_drain.sv
module swap_log_drain
    import swap_drain_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DEPTH  = 16,
    parameter int PAGE_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      swap_valid,
    input  logic [$clog2(NCH)-1:0]    swap_chan,
    input  logic [$clog2(NCH)-1:0]    swap_node,
    input  logic [PAGE_W-1:0]         swap_page,
    output logic                      swap_refused,
    input  logic                      room,
    input  logic                      cancel_valid,
    input  logic [$clog2(NCH)-1:0]    cancel_chan,
    input  logic [PAGE_W-1:0]         cancel_page,
    output logic                      cancel_miss,
    output logic                      wr_valid,
    output logic [$clog2(NCH)-1:0]    wr_chan,
    output logic [PAGE_W-1:0]         wr_page,
    output logic                      ack_valid,
    output logic [$clog2(NCH)-1:0]    ack_node,
    output logic [PAGE_W-1:0]         ack_page,
    output logic                      cack_valid,
    output logic [$clog2(NCH)-1:0]    cack_node,
    output logic [PAGE_W-1:0]         cack_page
);
    localparam int CH_W   = $clog2(NCH);
    localparam int NODE_W = CH_W;
    localparam int REC_W  = NODE_W + PAGE_W;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    drain_state_e     state_q, state_d;
    logic [CH_W-1:0]  sel_q;
    logic [CH_W-1:0]  pick;
    logic             any_loaded;
    logic             drain_now;

    logic [REC_W-1:0] head_w  [NCH];
    logic [REC_W-1:0] crec_w  [NCH];
    logic [CNT_W-1:0] fill_w  [NCH];
    logic             full_w  [NCH];
    logic             hit_w   [NCH];
    logic             taken_w [NCH];

    logic [REC_W-1:0] head_sel, crec_sel;
    logic             hit_sel, taken_sel, full_sel;

    assign drain_now = (state_q == ST_DRAIN) && room && (fill_w[sel_q] != '0);
    assign head_sel  = head_w[sel_q];
    assign crec_sel  = crec_w[cancel_chan];
    assign hit_sel   = hit_w[cancel_chan];
    assign taken_sel = taken_w[cancel_chan];
    assign full_sel  = full_w[swap_chan];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic push_en_c, pop_en_c, cancel_en_c;
        assign push_en_c   = swap_valid && (swap_chan == CH_W'(c));
        assign pop_en_c    = drain_now && (sel_q == CH_W'(c));
        assign cancel_en_c = cancel_valid && (cancel_chan == CH_W'(c));

        swap_chan_log #(
            .DEPTH  (DEPTH),
            .NODE_W (NODE_W),
            .PAGE_W (PAGE_W)
        ) u_log (
            .clk          (clk),
            .rst_n        (rst_n),
            .push_en      (push_en_c),
            .push_rec     ({swap_node, swap_page}),
            .pop_en       (pop_en_c),
            .cancel_en    (cancel_en_c),
            .cancel_page  (cancel_page),
            .head_rec     (head_w[c]),
            .fill         (fill_w[c]),
            .full         (full_w[c]),
            .cancel_hit   (hit_w[c]),
            .cancel_taken (taken_w[c]),
            .cancel_rec   (crec_w[c])
        );

        // R3: the picked channel is at least as loaded as this one.
        assert_pick_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_IDLE && room && any_loaded) |-> (fill_w[pick] >= fill_w[c]));

        // R3: equal loads resolve to the lower index.
        assert_pick_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_IDLE && room && any_loaded && fill_w[pick] == fill_w[c])
                |-> (pick <= CH_W'(c)));
    end

    swap_load_picker #(
        .NCH   (NCH),
        .CNT_W (CNT_W)
    ) u_picker (
        .fill       (fill_w),
        .best       (pick),
        .any_loaded (any_loaded)
    );

    // Next-state logic: SELECT and EXHAUST transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (room && any_loaded)     state_d = ST_DRAIN;
            ST_DRAIN: if (fill_w[sel_q] == '0)    state_d = ST_IDLE;
        endcase
    end

    // State register with the latched channel.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_DRAIN) sel_q <= pick;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid     <= 1'b0;
            wr_chan      <= '0;
            wr_page      <= '0;
            ack_valid    <= 1'b0;
            ack_node     <= '0;
            ack_page     <= '0;
            cack_valid   <= 1'b0;
            cack_node    <= '0;
            cack_page    <= '0;
            cancel_miss  <= 1'b0;
            swap_refused <= 1'b0;
        end else begin
            wr_valid     <= drain_now;
            wr_chan      <= sel_q;
            wr_page      <= head_sel[PAGE_W-1:0];
            ack_valid    <= drain_now;
            ack_node     <= head_sel[REC_W-1:PAGE_W];
            ack_page     <= head_sel[PAGE_W-1:0];
            cack_valid   <= cancel_valid && taken_sel;
            cack_node    <= crec_sel[REC_W-1:PAGE_W];
            cack_page    <= crec_sel[PAGE_W-1:0];
            cancel_miss  <= cancel_valid && !hit_sel;
            swap_refused <= swap_valid && full_sel;
        end
    end

    // R5: a non-empty selected channel is never abandoned.
    assert_drain_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && fill_w[sel_q] != '0) |=>
            (state_q == ST_DRAIN && sel_q == $past(sel_q)));

    // R4: a write only follows a cycle spent draining.
    assert_write_from_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($past(state_q) == ST_DRAIN));

    // R9: cancel on the head being drained yields one acknowledge only.
    assert_one_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_valid && drain_now && cancel_chan == sel_q &&
         cancel_page == head_sel[PAGE_W-1:0]) |=> (ack_valid && !cack_valid && !cancel_miss));

endmodule

// File: tb/swap_log_drain_tb.sv
module swap_log_drain_tb;
    localparam int NCH   = 8;
    localparam int DEPTH = 16;
    localparam int CH_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic swap_valid = 1'b0;
    logic [CH_W-1:0] swap_chan = '0, swap_node = '0;
    logic [15:0] swap_page = '0;
    logic room = 1'b0;
    logic cancel_valid = 1'b0;
    logic [CH_W-1:0] cancel_chan = '0;
    logic [15:0] cancel_page = '0;
    logic swap_refused, cancel_miss, wr_valid, ack_valid, cack_valid;
    logic [CH_W-1:0] wr_chan, ack_node, cack_node;
    logic [15:0] wr_page, ack_page, cack_page;

    always #4 clk = ~clk;

    swap_log_drain #(.NCH(NCH), .DEPTH(DEPTH), .PAGE_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .swap_valid(swap_valid), .swap_chan(swap_chan), .swap_node(swap_node),
        .swap_page(swap_page), .swap_refused(swap_refused), .room(room),
        .cancel_valid(cancel_valid), .cancel_chan(cancel_chan), .cancel_page(cancel_page),
        .cancel_miss(cancel_miss), .wr_valid(wr_valid), .wr_chan(wr_chan),
        .wr_page(wr_page), .ack_valid(ack_valid), .ack_node(ack_node),
        .ack_page(ack_page), .cack_valid(cack_valid), .cack_node(cack_node),
        .cack_page(cack_page)
    );

    int n_checks = 0;
    int n_err = 0;
    string phase = "R1 reset";

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", tag, phase, what, act, exp);
        end
    endtask

    // Behavioural reference: one queue per channel, record = node<<16 | page.
    int mq [NCH][$];
    int m_state = 0;
    int m_sel = 0;
    int sz [NCH];
    bit e_wr, e_cack, e_miss, e_ref;
    int e_chan, e_page, e_node, e_cnode, e_cpage;
    bit m_drain;
    int m_best, m_bc, m_idx, m_rec;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) mq[c].delete();
            m_state = 0; m_sel = 0;
            e_wr = 0; e_cack = 0; e_miss = 0; e_ref = 0;
        end else begin
            for (int c = 0; c < NCH; c++) sz[c] = mq[c].size();
            e_wr = 0; e_cack = 0; e_miss = 0; e_ref = 0;
            m_drain = 0;
            if (m_state == 1) begin
                if (sz[m_sel] == 0) m_state = 0;
                else if (room) m_drain = 1;
            end else if (room) begin
                m_best = -1; m_bc = 0;
                for (int c = 0; c < NCH; c++)
                    if (sz[c] > m_bc) begin m_bc = sz[c]; m_best = c; end
                if (m_best >= 0) begin m_sel = m_best; m_state = 1; end
            end
            if (m_drain) begin
                m_rec = mq[m_sel][0];
                e_wr = 1; e_chan = m_sel;
                e_page = m_rec & 32'hFFFF; e_node = m_rec >> 16;
            end
            if (cancel_valid) begin
                m_idx = -1;
                for (int i = 0; i < mq[int'(cancel_chan)].size(); i++)
                    if (m_idx < 0 && (mq[int'(cancel_chan)][i] & 32'hFFFF) == int'(cancel_page))
                        m_idx = i;
                if (m_idx < 0) e_miss = 1;
                else if (!(m_drain && int'(cancel_chan) == m_sel && m_idx == 0)) begin
                    e_cack = 1;
                    e_cnode = mq[int'(cancel_chan)][m_idx] >> 16;
                    e_cpage = mq[int'(cancel_chan)][m_idx] & 32'hFFFF;
                    mq[int'(cancel_chan)].delete(m_idx);
                end
            end
            if (m_drain) void'(mq[m_sel].pop_front());
            if (swap_valid) begin
                if (sz[int'(swap_chan)] == DEPTH) e_ref = 1;
                else mq[int'(swap_chan)].push_back((int'(swap_node) << 16) | int'(swap_page));
            end
        end
    end

    // Per-cycle comparison and scenario observation.
    bit cmp_en = 0;
    int chan_seq[$];
    int ch2_pages[$];
    int n_refused = 0, n_miss = 0, n100_ack = 0, n100_cack = 0;

    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            chk(wr_valid == e_wr, "R4", "wr_valid", int'(wr_valid), int'(e_wr));
            chk(ack_valid == e_wr, "R6", "ack_valid", int'(ack_valid), int'(e_wr));
            if (wr_valid && e_wr) begin
                chk(int'(wr_chan) == e_chan, "R3", "wr_chan", int'(wr_chan), e_chan);
                chk(int'(wr_page) == e_page, "R4", "wr_page", int'(wr_page), e_page);
                chk(int'(ack_node) == e_node, "R6", "ack_node", int'(ack_node), e_node);
                chk(int'(ack_page) == e_page, "R6", "ack_page", int'(ack_page), e_page);
            end
            chk(cack_valid == e_cack, "R7", "cack_valid", int'(cack_valid), int'(e_cack));
            if (cack_valid && e_cack) begin
                chk(int'(cack_node) == e_cnode, "R7", "cack_node", int'(cack_node), e_cnode);
                chk(int'(cack_page) == e_cpage, "R7", "cack_page", int'(cack_page), e_cpage);
            end
            chk(cancel_miss == e_miss, "R8", "cancel_miss", int'(cancel_miss), int'(e_miss));
            chk(swap_refused == e_ref, "R2", "swap_refused", int'(swap_refused), int'(e_ref));
            if (wr_valid && (chan_seq.size() == 0 || chan_seq[$] != int'(wr_chan)))
                chan_seq.push_back(int'(wr_chan));
            if (wr_valid && wr_chan == 3'd2) ch2_pages.push_back(int'(wr_page));
            if (swap_refused) n_refused++;
            if (cancel_miss) n_miss++;
            if (ack_valid && ack_page == 16'd100) n100_ack++;
            if (cack_valid && cack_page == 16'd100) n100_cack++;
        end
    end

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_err++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic push(input int ch, input int node, input int page);
        swap_valid = 1; swap_chan = CH_W'(ch); swap_node = CH_W'(node); swap_page = 16'(page);
        @(negedge clk);
        swap_valid = 0;
    endtask

    task automatic cancel(input int ch, input int page);
        cancel_valid = 1; cancel_chan = CH_W'(ch); cancel_page = 16'(page);
        @(negedge clk);
        cancel_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet while held in reset.
        chk(wr_valid == 0 && ack_valid == 0, "R1", "write/ack in reset", int'(wr_valid), 0);
        chk(cack_valid == 0 && cancel_miss == 0 && swap_refused == 0, "R1",
            "cancel/refuse in reset", int'(cack_valid), 0);
        rst_n = 1; cmp_en = 1;
        room = 1;
        repeat (4) @(negedge clk);
        room = 0;

        phase = "R2 fill to capacity";
        for (int i = 0; i < DEPTH + 1; i++) push(3, 3, 'h300 + i);
        push(1, 1, 'h110); push(1, 1, 'h111);
        push(6, 4, 'h160); push(6, 4, 'h161);
        @(negedge clk);
        chk(n_refused == 1, "R2", "refusal count", n_refused, 1);

        phase = "R5 hold channel";
        room = 1;
        repeat (4) @(negedge clk);
        room = 0;
        repeat (3) @(negedge clk);
        push(3, 5, 'h3F0);
        room = 1;
        repeat (40) @(negedge clk);
        room = 0;
        chk(chan_seq.size() == 3, "R3", "channels visited", chan_seq.size(), 3);
        if (chan_seq.size() == 3) begin
            chk(chan_seq[0] == 3, "R3", "first channel", chan_seq[0], 3);
            chk(chan_seq[1] == 1, "R3", "tie goes to lower index", chan_seq[1], 1);
            chk(chan_seq[2] == 6, "R5", "last channel", chan_seq[2], 6);
        end

        phase = "R7 mid cancel";
        for (int i = 10; i < 14; i++) push(2, 2, i);
        cancel(2, 12);
        room = 1;
        repeat (10) @(negedge clk);
        chk(ch2_pages.size() == 3, "R7", "pages written", ch2_pages.size(), 3);
        if (ch2_pages.size() == 3) begin
            chk(ch2_pages[0] == 10, "R7", "order 0", ch2_pages[0], 10);
            chk(ch2_pages[1] == 11, "R7", "order 1", ch2_pages[1], 11);
            chk(ch2_pages[2] == 13, "R7", "order 2", ch2_pages[2], 13);
        end

        phase = "R8 missing page";
        cancel(2, 99);
        @(negedge clk);
        chk(n_miss == 1, "R8", "miss count", n_miss, 1);

        phase = "R9 cancel collides with drain";
        room = 0;
        repeat (3) @(negedge clk);
        push(5, 6, 100); push(5, 6, 101); push(5, 6, 102);
        room = 1;
        @(negedge clk);
        cancel(5, 100);
        repeat (6) @(negedge clk);
        chk(n100_ack == 1, "R9", "drain acks for page 100", n100_ack, 1);
        chk(n100_cack == 0, "R9", "cancel acks for page 100", n100_cack, 0);
        chk(n_miss == 1, "R9", "no extra miss", n_miss, 1);

        phase = "R2 R4 R7 random congested";
        for (int k = 0; k < 1500; k++) begin
            room = ($urandom % 4) == 0;
            swap_valid = $urandom % 2; swap_chan = CH_W'($urandom % NCH);
            swap_node = CH_W'($urandom % NCH); swap_page = 16'($urandom % 8);
            cancel_valid = ($urandom % 5) == 0; cancel_chan = CH_W'($urandom % NCH);
            cancel_page = 16'($urandom % 8);
            @(negedge clk);
        end
        phase = "R3 R5 R9 random drain";
        for (int k = 0; k < 2500; k++) begin
            room = ($urandom % 4) != 0;
            swap_valid = $urandom % 2; swap_chan = CH_W'($urandom % NCH);
            swap_node = CH_W'($urandom % NCH); swap_page = 16'($urandom % 8);
            cancel_valid = ($urandom % 4) == 0; cancel_chan = CH_W'($urandom % NCH);
            cancel_page = 16'($urandom % 8);
            @(negedge clk);
        end
        swap_valid = 0; cancel_valid = 0; room = 1;
        repeat (300) @(negedge clk);
        cmp_en = 0;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule